// File: doc/BRIEF.md
# Microcoded Accumulator Datapath Executor

This block is the datapath half of a microprogrammed accumulator machine. In every clock cycle it takes three independently encoded 3-bit micro-operation fields from the current control word and carries out the register transfers they select on four registers: an address register, a program counter, a data register and an accumulator. It also does the reads and writes to a word-addressed store indexed by the address register. All transfers selected in a cycle take effect on the same clock edge. Each one reads the register values from before that edge, so one control word can swap the accumulator and the data register.

The surrounding sequencer chooses the next control-store address. To do that it needs status from this block: the indirect flag and the opcode taken from the data register, and the sign and zero-test of the accumulator. The instruction word held in the data register has the indirect flag in its top bit, the opcode in the next four bits and the operand address in the low address-width bits.

Top module: `udp_exec`

## Requirements
- R1: While `rst_n` is low, the address register, program counter, data register and accumulator all read zero. The store keeps its contents across reset.
- R2: Field A (`uop_a_i`) encodings: 000 no-op, 001 AC←AC+DR, 010 AC←0, 011 AC←AC+1, 100 AC←DR, 101 AR←DR[10:0], 110 AR←PC, 111 store word at AR ← DR.
- R3: Field B (`uop_b_i`) encodings: 000 no-op, 001 AC←AC−DR, 010 AC←AC|DR, 011 AC←AC&DR, 100 DR←store word at AR, 101 DR←AC, 110 DR←DR+1, 111 DR[10:0]←PC.
- R4: Field C (`uop_c_i`) encodings: 000 no-op, 001 AC←AC^DR, 010 AC←~AC, 011 AC shifted left one place, 100 AC shifted right one place, 101 PC←PC+1, 110 PC←AR. Code 111 changes no register and no store word.
- R5: Every transfer reads pre-edge values. Field A 100 together with field B 101 swaps AC and DR. Field A 110 together with field C 110 swaps AR and PC.
- R6: When more than one field targets AC in a cycle, field A wins over field B and field B wins over field C. Transfers from the losing fields to other registers still happen.
- R7: A store read lands in DR at the same edge it is requested. A write uses the pre-edge AR and DR. A read and a write to the same word in one cycle return the old word.
- R8: Both shifts insert a zero into the vacated bit.
- R9: Field B 111 leaves DR[15:11] unchanged.
- R10: Status outputs: `ind_o`=DR[15], `opc_o`=DR[14:11], `sign_o`=AC[15], and `zero_o` is high exactly when AC is zero.
- R11: Arithmetic wraps: AC and DR modulo 2^16, PC modulo 2^11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the four registers |
| uop_a_i | input | 3 | Micro-operation field A |
| uop_b_i | input | 3 | Micro-operation field B |
| uop_c_i | input | 3 | Micro-operation field C |
| ar_o | output | 11 | Address register |
| pc_o | output | 11 | Program counter |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ind_o | output | 1 | Indirect flag from DR |
| opc_o | output | 4 | Opcode from DR |
| sign_o | output | 1 | Accumulator sign |
| zero_o | output | 1 | Accumulator equals zero |

## Verification
The bench goes after the swaps. A design that let one transfer see another's result would copy one value into both registers instead of exchanging them. It drives all three fields at AC in one cycle, which a wrong priority order shows as the wrong arithmetic result. It reads and writes the same word in one cycle: a write-first store would return the new word to DR. It also covers shift fill, the partial DR load that must keep the top five bits, and wrap-around of DR, AC and PC. An exhaustive sweep of all 512 field combinations and a long pseudo-random run then catch any encoding that touches a register it should not.

// File: rtl/udp_pkg.sv
package udp_pkg;

   typedef enum logic [2:0] {
      FA_NOP, FA_ADD, FA_CLR, FA_INC, FA_LDDR, FA_ARDR, FA_ARPC, FA_STORE
   } fa_e;

   typedef enum logic [2:0] {
      FB_NOP, FB_SUB, FB_OR, FB_AND, FB_LOAD, FB_DRAC, FB_DRINC, FB_DRPC
   } fb_e;

   typedef enum logic [2:0] {
      FC_NOP, FC_XOR, FC_CPL, FC_SHL, FC_SHR, FC_PCINC, FC_PCAR, FC_RSV
   } fc_e;

   typedef enum logic [3:0] {
      AC_KEEP, AC_ADD, AC_SUB, AC_INC, AC_CLR, AC_DR,
      AC_OR, AC_AND, AC_XOR, AC_CPL, AC_SHL, AC_SHR
   } ac_op_e;

   typedef enum logic [2:0] {
      DR_KEEP, DR_MEM, DR_AC, DR_INC, DR_PC
   } dr_op_e;

   typedef enum logic [1:0] {
      AR_KEEP, AR_DR, AR_PC
   } ar_op_e;

   typedef enum logic [1:0] {
      PC_KEEP, PC_INC, PC_AR
   } pc_op_e;

   typedef struct packed {
      ac_op_e ac_op;
      dr_op_e dr_op;
      ar_op_e ar_op;
      pc_op_e pc_op;
      logic   mem_we;
   } udp_ctl_t;

endpackage

// File: rtl/udp_decode.sv
module udp_decode
   import udp_pkg::*;
(
   input  logic [2:0] fa_i,
   input  logic [2:0] fb_i,
   input  logic [2:0] fc_i,
   output udp_ctl_t   ctl_o
);

   ac_op_e ac_a, ac_b, ac_c;

   // per-field AC request, AC_KEEP when the field does not target AC
   always_comb begin
      case (fa_e'(fa_i))
         FA_ADD:  ac_a = AC_ADD;
         FA_CLR:  ac_a = AC_CLR;
         FA_INC:  ac_a = AC_INC;
         FA_LDDR: ac_a = AC_DR;
         default: ac_a = AC_KEEP;
      endcase
      case (fb_e'(fb_i))
         FB_SUB:  ac_b = AC_SUB;
         FB_OR:   ac_b = AC_OR;
         FB_AND:  ac_b = AC_AND;
         default: ac_b = AC_KEEP;
      endcase
      case (fc_e'(fc_i))
         FC_XOR:  ac_c = AC_XOR;
         FC_CPL:  ac_c = AC_CPL;
         FC_SHL:  ac_c = AC_SHL;
         FC_SHR:  ac_c = AC_SHR;
         default: ac_c = AC_KEEP;
      endcase
   end

   always_comb begin
      // fixed priority: field A, then B, then C
      if (ac_a != AC_KEEP)      ctl_o.ac_op = ac_a;
      else if (ac_b != AC_KEEP) ctl_o.ac_op = ac_b;
      else                      ctl_o.ac_op = ac_c;

      case (fb_e'(fb_i))
         FB_LOAD:  ctl_o.dr_op = DR_MEM;
         FB_DRAC:  ctl_o.dr_op = DR_AC;
         FB_DRINC: ctl_o.dr_op = DR_INC;
         FB_DRPC:  ctl_o.dr_op = DR_PC;
         default:  ctl_o.dr_op = DR_KEEP;
      endcase

      case (fa_e'(fa_i))
         FA_ARDR: ctl_o.ar_op = AR_DR;
         FA_ARPC: ctl_o.ar_op = AR_PC;
         default: ctl_o.ar_op = AR_KEEP;
      endcase

      case (fc_e'(fc_i))
         FC_PCINC: ctl_o.pc_op = PC_INC;
         FC_PCAR:  ctl_o.pc_op = PC_AR;
         default:  ctl_o.pc_op = PC_KEEP;
      endcase

      ctl_o.mem_we = (fa_e'(fa_i) == FA_STORE);
   end

endmodule

// File: rtl/udp_acu.sv
module udp_acu
   import udp_pkg::*;
#(
   parameter int DW         = 16,
   parameter bit SHARED_ADD = 1'b1
)(
   input  logic [DW-1:0] ac_i,
   input  logic [DW-1:0] dr_i,
   input  ac_op_e        op_i,
   output logic [DW-1:0] ac_o
);

   logic [DW-1:0] sum;

   generate
      if (SHARED_ADD) begin : g_shared
         // one carry chain serves add, subtract and increment
         logic [DW-1:0] opnd;
         logic          cin;
         always_comb begin
            case (op_i)
               AC_SUB:  begin opnd = ~dr_i;     cin = 1'b1; end
               AC_INC:  begin opnd = '0;        cin = 1'b1; end
               default: begin opnd = dr_i;      cin = 1'b0; end
            endcase
         end
         assign sum = ac_i + opnd + {{(DW-1){1'b0}}, cin};
      end else begin : g_split
         logic [DW-1:0] s_add, s_sub, s_inc;
         assign s_add = ac_i + dr_i;
         assign s_sub = ac_i - dr_i;
         assign s_inc = ac_i + {{(DW-1){1'b0}}, 1'b1};
         always_comb begin
            case (op_i)
               AC_SUB:  sum = s_sub;
               AC_INC:  sum = s_inc;
               default: sum = s_add;
            endcase
         end
      end
   endgenerate

   always_comb begin
      case (op_i)
         AC_ADD, AC_SUB, AC_INC: ac_o = sum;
         AC_CLR:  ac_o = '0;
         AC_DR:   ac_o = dr_i;
         AC_OR:   ac_o = ac_i | dr_i;
         AC_AND:  ac_o = ac_i & dr_i;
         AC_XOR:  ac_o = ac_i ^ dr_i;
         AC_CPL:  ac_o = ~ac_i;
         AC_SHL:  ac_o = {ac_i[DW-2:0], 1'b0};
         AC_SHR:  ac_o = {1'b0, ac_i[DW-1:1]};
         default: ac_o = ac_i;
      endcase
   end

endmodule

// File: rtl/udp_store.sv
module udp_store #(
   parameter int AW = 11,
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
   end

   // combinational read: returns the word as it stood before this edge
   assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/udp_exec.sv
module udp_exec
   import udp_pkg::*;
#(
   parameter int AW         = 11,
   parameter int DW         = 16,
   parameter bit SHARED_ADD = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    uop_a_i,
   input  logic [2:0]    uop_b_i,
   input  logic [2:0]    uop_c_i,
   output logic [AW-1:0] ar_o,
   output logic [AW-1:0] pc_o,
   output logic [DW-1:0] dr_o,
   output logic [DW-1:0] ac_o,
   output logic          ind_o,
   output logic [DW-AW-2:0] opc_o,
   output logic          sign_o,
   output logic          zero_o
);

   localparam int OPW = DW - AW - 1;

   generate
      if (OPW < 1) begin : g_bad_width
         $error("udp_exec: DW must exceed AW+1 to hold flag and opcode");
      end
      if (AW < 2) begin : g_bad_aw
         $error("udp_exec: AW must be at least 2");
      end
   endgenerate

   udp_ctl_t      ctl;
   logic [AW-1:0] ar_q, pc_q, ar_d, pc_d;
   logic [DW-1:0] dr_q, ac_q, dr_d, ac_d, rd_word;

   udp_decode u_dec (
      .fa_i  (uop_a_i),
      .fb_i  (uop_b_i),
      .fc_i  (uop_c_i),
      .ctl_o (ctl)
   );

   udp_acu #(.DW(DW), .SHARED_ADD(SHARED_ADD)) u_acu (
      .ac_i (ac_q),
      .dr_i (dr_q),
      .op_i (ctl.ac_op),
      .ac_o (ac_d)
   );

   udp_store #(.AW(AW), .DW(DW)) u_store (
      .clk     (clk),
      .we_i    (ctl.mem_we),
      .addr_i  (ar_q),
      .wdata_i (dr_q),
      .rdata_o (rd_word)
   );

   always_comb begin
      case (ctl.dr_op)
         DR_MEM:  dr_d = rd_word;
         DR_AC:   dr_d = ac_q;
         DR_INC:  dr_d = dr_q + {{(DW-1){1'b0}}, 1'b1};
         DR_PC:   dr_d = {dr_q[DW-1:AW], pc_q};
         default: dr_d = dr_q;
      endcase
      case (ctl.ar_op)
         AR_DR:   ar_d = dr_q[AW-1:0];
         AR_PC:   ar_d = pc_q;
         default: ar_d = ar_q;
      endcase
      case (ctl.pc_op)
         PC_INC:  pc_d = pc_q + {{(AW-1){1'b0}}, 1'b1};
         PC_AR:   pc_d = ar_q;
         default: pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_q <= '0;
         pc_q <= '0;
         dr_q <= '0;
         ac_q <= '0;
      end else begin
         ar_q <= ar_d;
         pc_q <= pc_d;
         dr_q <= dr_d;
         ac_q <= ac_d;
      end
   end

   assign ar_o   = ar_q;
   assign pc_o   = pc_q;
   assign dr_o   = dr_q;
   assign ac_o   = ac_q;
   assign ind_o  = dr_q[DW-1];
   assign opc_o  = dr_q[DW-2:AW];
   assign sign_o = ac_q[DW-1];
   assign zero_o = ~|ac_q;

endmodule

// File: rtl/udp_exec_chk.sv
module udp_exec_chk #(
   parameter int AW = 11,
   parameter int DW = 16
)(
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    fa,
   input logic [2:0]    fb,
   input logic [2:0]    fc,
   input logic [AW-1:0] ar,
   input logic [AW-1:0] pc,
   input logic [DW-1:0] dr,
   input logic [DW-1:0] ac
);

   // R5: AC/DR exchange uses pre-edge values
   a_r5_swap_ac_dr: assert property (@(posedge clk) disable iff (!rst_n)
      (fa == 3'b100 && fb == 3'b101) |=> (ac == $past(dr) && dr == $past(ac)));

   // R5: AR/PC exchange uses pre-edge values
   a_r5_swap_ar_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (fa == 3'b110 && fc == 3'b110) |=> (ar == $past(pc) && pc == $past(ar)));

   // R4: PC only moves under field C 101 or 110
   a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fc != 3'b101 && fc != 3'b110) |=> $stable(pc));

   // R2: AR only moves under field A 101 or 110
   a_r2_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fa != 3'b101 && fa != 3'b110) |=> $stable(ar));

   // R3: DR only moves under a field B code that targets it
   a_r3_dr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fb[2] == 1'b0) |=> $stable(dr));

   // R8: left shift fills with zero
   a_r8_shl_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (fa == 3'b000 && fb == 3'b000 && fc == 3'b011) |=> (ac == {$past(ac[DW-2:0]), 1'b0}));

   // R9: partial DR load keeps the top bits
   a_r9_dr_top: assert property (@(posedge clk) disable iff (!rst_n)
      (fb == 3'b111) |=> (dr[DW-1:AW] == $past(dr[DW-1:AW]) && dr[AW-1:0] == $past(pc)));

   // R11: PC increment wraps modulo 2^AW
   a_r11_pc_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (fc == 3'b101) |=> (pc == $past(pc) + 1'b1));

endmodule

bind udp_exec udp_exec_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .fa    (uop_a_i),
   .fb    (uop_b_i),
   .fc    (uop_c_i),
   .ar    (ar_o),
   .pc    (pc_o),
   .dr    (dr_o),
   .ac    (ac_o)
);

// File: tb/udp_exec_tb_top.sv
module udp_exec_tb_top;

   localparam int AW    = 11;
   localparam int DW    = 16;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    fa, fb, fc;
   logic [AW-1:0] ar, pc;
   logic [DW-1:0] dr, ac;
   logic          ind, sgn, zro;
   logic [3:0]    opc;

   always #4 clk = ~clk;   // 125 MHz

   udp_exec #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .uop_a_i(fa), .uop_b_i(fb), .uop_c_i(fc),
      .ar_o(ar), .pc_o(pc), .dr_o(dr), .ac_o(ac),
      .ind_o(ind), .opc_o(opc), .sign_o(sgn), .zero_o(zro)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [DW-1:0] m_mem [DEPTH];
   logic [AW-1:0] m_ar, m_pc;
   logic [DW-1:0] m_dr, m_ac;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "AR", 32'(ar), 32'(m_ar));
      chk(tag, "PC", 32'(pc), 32'(m_pc));
      chk(tag, "DR", 32'(dr), 32'(m_dr));
      chk(tag, "AC", 32'(ac), 32'(m_ac));
      chk({tag, "/R10"}, "ind", 32'(ind), 32'(m_dr[15]));
      chk({tag, "/R10"}, "opc", 32'(opc), 32'(m_dr[14:11]));
      chk({tag, "/R10"}, "sign", 32'(sgn), 32'(m_ac[15]));
      chk({tag, "/R10"}, "zero", 32'(zro), 32'(m_ac == 16'h0));
   endtask

   // one control word; reference result worked out from the requirement text
   task automatic step(input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] c, input string tag);
      logic [AW-1:0] n_ar, n_pc;
      logic [DW-1:0] n_dr, n_ac;
      @(negedge clk);
      fa = a; fb = b; fc = c;
      n_ar = m_ar; n_pc = m_pc; n_dr = m_dr; n_ac = m_ac;
      // lowest priority first so the higher fields overwrite AC
      case (c)
         3'd1: n_ac = m_ac ^ m_dr;
         3'd2: n_ac = ~m_ac;
         3'd3: n_ac = m_ac << 1;
         3'd4: n_ac = m_ac >> 1;
         3'd5: n_pc = m_pc + 11'd1;
         3'd6: n_pc = m_ar;
         default: ;
      endcase
      case (b)
         3'd1: n_ac = m_ac - m_dr;
         3'd2: n_ac = m_ac | m_dr;
         3'd3: n_ac = m_ac & m_dr;
         3'd4: n_dr = m_mem[m_ar];
         3'd5: n_dr = m_ac;
         3'd6: n_dr = m_dr + 16'd1;
         3'd7: n_dr = {m_dr[15:11], m_pc};
         default: ;
      endcase
      case (a)
         3'd1: n_ac = m_ac + m_dr;
         3'd2: n_ac = 16'h0;
         3'd3: n_ac = m_ac + 16'd1;
         3'd4: n_ac = m_dr;
         3'd5: n_ar = m_dr[10:0];
         3'd6: n_ar = m_pc;
         default: ;
      endcase
      if (a == 3'd7) m_mem[m_ar] = m_dr;
      @(posedge clk);
      #2;
      m_ar = n_ar; m_pc = n_pc; m_dr = n_dr; m_ac = n_ac;
      compare_all(tag);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      fa = 3'd0; fb = 3'd0; fc = 3'd0;
      rst_n = 1'b0;
      m_ar = '0; m_pc = '0; m_dr = '0; m_ac = '0;
      repeat (3) @(posedge clk);
      #2;
      compare_all("R1");
      @(negedge clk);
      rst_n = 1'b1;

      // fill the store: word k gets k+1 (R7 writes with pre-edge AR/DR)
      for (int k = 0; k < DEPTH; k++) begin
         step(3'd6, 3'd6, 3'd5, "R3");
         step(3'd7, 3'd0, 3'd0, "R7");
      end

      // AC build-up, shifts, complement (R2, R4, R8)
      step(3'd2, 3'd0, 3'd0, "R2");
      step(3'd3, 3'd0, 3'd0, "R2");
      step(3'd3, 3'd0, 3'd0, "R2");
      step(3'd3, 3'd0, 3'd0, "R2");
      step(3'd0, 3'd0, 3'd3, "R8");
      step(3'd0, 3'd0, 3'd4, "R8");
      step(3'd0, 3'd0, 3'd4, "R8");
      step(3'd0, 3'd0, 3'd2, "R4");
      step(3'd0, 3'd0, 3'd3, "R8");
      step(3'd0, 3'd0, 3'd4, "R8");
      // load, exchange, priority, reserved code
      step(3'd5, 3'd0, 3'd0, "R2");
      step(3'd0, 3'd4, 3'd0, "R7");
      step(3'd4, 3'd5, 3'd0, "R5");
      step(3'd3, 3'd1, 3'd2, "R6");
      step(3'd0, 3'd1, 3'd2, "R6");
      step(3'd0, 3'd0, 3'd7, "R4");
      // same-word read and write returns the old word
      step(3'd7, 3'd4, 3'd0, "R7");
      step(3'd0, 3'd4, 3'd0, "R7");
      // AR/PC swap and partial DR load
      step(3'd6, 3'd0, 3'd6, "R5");
      step(3'd0, 3'd7, 3'd0, "R9");
      // wrap of DR, PC, AC
      step(3'd2, 3'd0, 3'd0, "R11");
      step(3'd0, 3'd0, 3'd2, "R11");
      step(3'd0, 3'd5, 3'd0, "R11");
      step(3'd5, 3'd6, 3'd0, "R11");
      step(3'd0, 3'd5, 3'd0, "R11");
      step(3'd5, 3'd0, 3'd0, "R11");
      step(3'd0, 3'd0, 3'd6, "R11");
      step(3'd0, 3'd0, 3'd5, "R11");
      step(3'd3, 3'd0, 3'd0, "R11");
      step(3'd0, 3'd7, 3'd0, "R9");

      // every field combination
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int c = 0; c < 8; c++)
               step(3'(a), 3'(b), 3'(c), "R6");

      // pseudo-random control words
      lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < 3000; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         step(lfsr[2:0], lfsr[6:4], lfsr[10:8], "R3");
      end

      // reset in mid-run clears registers, store survives
      @(negedge clk);
      rst_n = 1'b0;
      m_ar = '0; m_pc = '0; m_dr = '0; m_ac = '0;
      @(posedge clk);
      #2;
      compare_all("R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(3'd0, 3'd4, 3'd0, "R1");
      step(3'd6, 3'd0, 3'd5, "R1");
      step(3'd0, 3'd4, 3'd0, "R1");

      done = 1;
      summary();
      $finish;
   end

endmodule